// File: doc/BRIEF.md
# External Bus Read Responder

This block is a read-only slave on a shared external bus. It watches the start-of-transfer strobe, its chip select and the read/write line. When a master begins a read whose address falls inside the block's window, the block takes the word index from the address, turns on its data-bus output enable, and presents a 32-bit word from a computed constant table. After a configurable number of wait cycles it pulls its active-low acknowledge low for one cycle. It then releases the data bus on the very next edge, which is well inside the two-cycle release deadline the bus imposes.

The data word comes from a parameterised table: entry `i` holds `(i * 0x9E3779B1) ^ SEED`, truncated to the data width. The block can be placed at any window in the address space that is aligned to its own size. If chip select drops or the transfer turns into a write while a read is in progress, the responder withdraws at once. It does not acknowledge that transfer.

Top module: `ebus_rd_responder`

## Requirements
- R1: A transfer is accepted only on a rising clock edge where `start_n`=0, `sel_n`=0, `rnw`=1 and the address is inside the window. Starts that are writes, or that have `sel_n`=1, cause no response.
- R2: On the edge after acceptance, `dq_oe` goes to 1. While `dq_oe`=1, `dq_out` equals `(i*0x9E3779B1)^SEED`, where `i` is address bits [IDX_W+1:2] captured at acceptance. This value stays stable for the whole transfer.
- R3: `ack_n` goes low for exactly one cycle. It goes low on the edge that comes WAIT_STATES+1 edges after the accepting edge.
- R4: `ack_n` is never low unless `dq_oe` is 1.
- R5: `dq_oe` returns to 0 on the edge that ends the acknowledge cycle. This is one cycle after acknowledge, inside the two-cycle release deadline.
- R6: If `sel_n`=1 or `rnw`=0 is sampled while a transfer is in progress, `dq_oe` is 0 and `ack_n` is 1 from the next edge on. No acknowledge follows for that transfer.
- R7: A new `start_n` pulse during a transfer in progress is ignored. The captured index, the data and the acknowledge timing stay those of the first start.
- R8: An address whose bits [31:IDX_W+2] differ from those of BASE gets no response: `dq_oe` stays 0 and `ack_n` stays 1.
- R9: During reset and after it, `dq_oe`=0, `ack_n`=1 and `dq_out`=0. `dq_out` is 0 whenever `dq_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | bus clock |
| rst_n | input | 1 | asynchronous active-low reset |
| start_n | input | 1 | transfer-start strobe, active low |
| sel_n | input | 1 | chip select, active low |
| rnw | input | 1 | 1 = read, 0 = write |
| addr | input | 32 | transfer address |
| dq_out | output | 32 | read data to the bus (zero when not driving) |
| dq_oe | output | 1 | data-bus output enable for the tri-state buffer |
| ack_n | output | 1 | transfer acknowledge, active low |

## Verification
The case that is hardest to reach from the ports is a disturbance that lands in the middle of a transfer. This is either chip select or the read/write line changing during the wait cycles, or a second start strobe arriving before acknowledge. The master model in the bench produces these on purpose. It starts a read and then, on the first driving cycle, either drops select, flips to write, or pulses start again with another in-window address. It then checks that the bus is released or that the original data and timing survive. Random reads, with addresses drawn inside and outside the window, cover the rest of the decode and the data table.

// File: rtl/ebus_rd_pkg.sv
package ebus_rd_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_DRIVE = 2'd1,
      ST_ACK   = 2'd2
   } rsp_state_t;

   // Constant data pattern for table entry idx.
   function automatic logic [31:0] mix_word(input logic [31:0] idx, input logic [31:0] seed);
      logic [31:0] prod;
      prod = idx * 32'h9E37_79B1;
      return prod ^ seed;
   endfunction

endpackage

// File: rtl/ebus_rd_decode.sv
module ebus_rd_decode #(
   parameter int          ADDR_W = 32,
   parameter int          IDX_W  = 4,
   parameter logic [31:0] BASE   = 32'h4000_0000
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic [IDX_W-1:0]  idx
);
   localparam int TAG_LO = IDX_W + 2;

   logic [1:0] unused_byte_lane;

   assign hit              = (addr[ADDR_W-1:TAG_LO] == BASE[ADDR_W-1:TAG_LO]);
   assign idx              = addr[TAG_LO-1:2];
   assign unused_byte_lane = addr[1:0];
endmodule

// File: rtl/ebus_rd_waitcnt.sv
module ebus_rd_waitcnt #(
   parameter int WAIT_STATES = 2,
   parameter int CNT_W       = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic dec,
   output logic done
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= CNT_W'(WAIT_STATES);
      end else if (dec && cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign done = (cnt == '0);
endmodule

// File: rtl/ebus_rd_rom.sv
module ebus_rd_rom #(
   parameter int          DATA_W = 32,
   parameter int          IDX_W  = 4,
   parameter logic [31:0] SEED   = 32'h5A5A_0F0F
) (
   input  logic [IDX_W-1:0]  idx,
   output logic [DATA_W-1:0] word
);
   import ebus_rd_pkg::*;

   localparam int DEPTH = 1 << IDX_W;

   logic [DATA_W-1:0] table_q [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_entry
      assign table_q[g] = DATA_W'(mix_word(32'(g), SEED));
   end

   assign word = table_q[idx];
endmodule

// File: rtl/ebus_rd_responder.sv
module ebus_rd_responder #(
   parameter int          ADDR_W      = 32,
   parameter int          DATA_W      = 32,
   parameter int          IDX_W       = 4,
   parameter int          WAIT_STATES = 2,
   parameter logic [31:0] BASE        = 32'h4000_0000,
   parameter logic [31:0] SEED        = 32'h5A5A_0F0F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_n,
   input  logic              sel_n,
   input  logic              rnw,
   input  logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] dq_out,
   output logic              dq_oe,
   output logic              ack_n
);
   import ebus_rd_pkg::*;

   localparam int CNT_RAW = $clog2(WAIT_STATES + 1);
   localparam int CNT_W   = (CNT_RAW < 1) ? 1 : CNT_RAW;

   if (ADDR_W != 32) begin : g_chk_addr
      $error("ADDR_W must be 32");
   end
   if (DATA_W < 1 || DATA_W > 32) begin : g_chk_data
      $error("DATA_W must be 1..32");
   end
   if (IDX_W < 1 || IDX_W > 10) begin : g_chk_idx
      $error("IDX_W must be 1..10");
   end
   if (WAIT_STATES < 0 || WAIT_STATES > 255) begin : g_chk_ws
      $error("WAIT_STATES must be 0..255");
   end
   if ((BASE & ((32'd1 << (IDX_W + 2)) - 32'd1)) != 32'd0) begin : g_chk_base
      $error("BASE must be aligned to the window size");
   end

   rsp_state_t        state;
   logic              hit;
   logic [IDX_W-1:0]  dec_idx;
   logic [IDX_W-1:0]  cur_idx;
   logic [DATA_W-1:0] rom_word;
   logic              accept;
   logic              abort;
   logic              wait_done;

   ebus_rd_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .BASE(BASE)) u_decode (
      .addr (addr),
      .hit  (hit),
      .idx  (dec_idx)
   );

   ebus_rd_rom #(.DATA_W(DATA_W), .IDX_W(IDX_W), .SEED(SEED)) u_rom (
      .idx  (cur_idx),
      .word (rom_word)
   );

   assign accept = (state == ST_IDLE) && !start_n && !sel_n && rnw && hit;
   assign abort  = sel_n || !rnw;

   if (WAIT_STATES == 0) begin : g_no_wait
      assign wait_done = 1'b1;
   end else begin : g_wait
      ebus_rd_waitcnt #(.WAIT_STATES(WAIT_STATES), .CNT_W(CNT_W)) u_wait (
         .clk   (clk),
         .rst_n (rst_n),
         .load  (accept),
         .dec   (state == ST_DRIVE),
         .done  (wait_done)
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cur_idx <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (accept) begin
                  state   <= ST_DRIVE;
                  cur_idx <= dec_idx;
               end
            end
            ST_DRIVE: begin
               if (abort) begin
                  state <= ST_IDLE;
               end else if (wait_done) begin
                  state <= ST_ACK;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign dq_oe  = (state != ST_IDLE);
   assign ack_n  = (state != ST_ACK);
   assign dq_out = dq_oe ? rom_word : '0;

   // R4: acknowledge only while the data bus is driven
   a_r4_ack_needs_oe: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_n |-> dq_oe);

   // R3: acknowledge lasts a single cycle
   a_r3_ack_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_n |=> ack_n);

   // R5: bus released on the edge that ends acknowledge
   a_r5_release_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_n |=> !dq_oe);

   // R6: select dropped or write seen -> withdraw next cycle
   a_r6_withdraw: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_n || !rnw) |=> (!dq_oe && ack_n));

   // R2: data stable while driven
   a_r2_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |=> (!dq_oe || $stable(dq_out)));

   // R9: data lines zero when not driving
   a_r9_quiet_data: assert property (@(posedge clk) disable iff (!rst_n)
      !dq_oe |-> (dq_out == '0));
endmodule

// File: tb/test_ebus_rd_responder.sv
module test_ebus_rd_responder;
   localparam int          WS    = 2;
   localparam int          IDX_W = 4;
   localparam logic [31:0] BASE  = 32'h4000_0000;
   localparam logic [31:0] SEED  = 32'h5A5A_0F0F;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_n = 1'b1;
   logic        sel_n = 1'b1;
   logic        rnw = 1'b1;
   logic [31:0] addr = '0;
   logic [31:0] dq_out;
   logic        dq_oe;
   logic        ack_n;

   int total = 0;
   int bad = 0;

   always #10 clk = ~clk;

   ebus_rd_responder #(
      .IDX_W(IDX_W), .WAIT_STATES(WS), .BASE(BASE), .SEED(SEED)
   ) i_ebus_rd_responder (
      .clk(clk), .rst_n(rst_n), .start_n(start_n), .sel_n(sel_n), .rnw(rnw),
      .addr(addr), .dq_out(dq_out), .dq_oe(dq_oe), .ack_n(ack_n)
   );

   function automatic logic [31:0] exp_word(input logic [31:0] a);
      logic [31:0] i;
      i = (a >> 2) & ((32'd1 << IDX_W) - 32'd1);
      return (i * 32'h9E37_79B1) ^ SEED;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
      end
   endtask

   task automatic idle_chk(input string tag);
      chk(dq_oe == 1'b0, tag, {31'd0, dq_oe}, 32'd0);
      chk(ack_n == 1'b1, tag, {31'd0, ack_n}, 32'd1);
   endtask

   // mode 0: plain, 1: drop select, 2: turn to write, 3: second start
   task automatic do_read(input logic [31:0] a, input bit hit, input int mode, input logic [31:0] alt);
      @(negedge clk);
      start_n = 1'b0; sel_n = 1'b0; rnw = 1'b1; addr = a;
      @(negedge clk);
      start_n = 1'b1;
      if (!hit) begin
         for (int k = 0; k < 3; k++) begin
            idle_chk("R8 out-of-window");
            @(negedge clk);
         end
         sel_n = 1'b1;
         return;
      end
      chk(dq_oe == 1'b1, "R2 oe after accept", {31'd0, dq_oe}, 32'd1);
      chk(dq_out == exp_word(a), "R2 data", dq_out, exp_word(a));
      if (mode == 1 || mode == 2) begin
         if (mode == 1) sel_n = 1'b1; else rnw = 1'b0;
         for (int k = 0; k < WS + 2; k++) begin
            @(negedge clk);
            idle_chk(mode == 1 ? "R6 select dropped" : "R6 turned to write");
         end
         sel_n = 1'b1; rnw = 1'b1;
         return;
      end
      if (mode == 3) begin
         start_n = 1'b0; addr = alt;
      end
      for (int k = 1; k <= WS; k++) begin
         @(negedge clk);
         start_n = 1'b1;
         chk(dq_oe && ack_n, "R3 wait cycle", {30'd0, dq_oe, ack_n}, 32'd2);
         chk(dq_out == exp_word(a), mode == 3 ? "R7 data kept" : "R2 data stable", dq_out, exp_word(a));
      end
      @(negedge clk);
      start_n = 1'b1;
      chk(ack_n == 1'b0, "R3 ack timing", {31'd0, ack_n}, 32'd0);
      chk(dq_oe == 1'b1, "R4 oe with ack", {31'd0, dq_oe}, 32'd1);
      chk(dq_out == exp_word(a), mode == 3 ? "R7 data at ack" : "R2 data at ack", dq_out, exp_word(a));
      @(negedge clk);
      chk(dq_oe == 1'b0, "R5 bus released", {31'd0, dq_oe}, 32'd0);
      chk(ack_n == 1'b1, "R3 ack single", {31'd0, ack_n}, 32'd1);
      chk(dq_out == 32'd0, "R9 data zero when idle", dq_out, 32'd0);
      sel_n = 1'b1;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      logic [31:0] a;
      bit hit;
      void'($urandom(32'd1234));
      repeat (2) @(negedge clk);
      idle_chk("R9 in reset");
      chk(dq_out == 32'd0, "R9 data in reset", dq_out, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      idle_chk("R9 after reset");

      // R1: write start ignored
      @(negedge clk);
      start_n = 1'b0; sel_n = 1'b0; rnw = 1'b0; addr = BASE | 32'h8;
      @(negedge clk);
      start_n = 1'b1;
      for (int k = 0; k < 3; k++) begin
         idle_chk("R1 write start ignored");
         @(negedge clk);
      end
      sel_n = 1'b1; rnw = 1'b1;
      // R1: start without select ignored
      start_n = 1'b0; addr = BASE | 32'h4;
      @(negedge clk);
      start_n = 1'b1;
      for (int k = 0; k < 3; k++) begin
         idle_chk("R1 unselected start ignored");
         @(negedge clk);
      end

      do_read(BASE, 1'b1, 0, 32'd0);
      do_read(BASE | 32'h3C, 1'b1, 0, 32'd0);
      do_read(BASE ^ 32'h0000_0040, 1'b0, 0, 32'd0);
      do_read(BASE | 32'h14, 1'b1, 1, 32'd0);
      do_read(BASE | 32'h18, 1'b1, 2, 32'd0);
      do_read(BASE | 32'h1C, 1'b1, 3, BASE | 32'h20);

      for (int n = 0; n < 40; n++) begin
         hit = ($urandom % 4) != 0;
         a = $urandom;
         if (hit) a = BASE | (a & 32'h3F);
         else if ((a & 32'hFFFF_FFC0) == BASE) a = a ^ 32'h8000_0000;
         do_read(a, hit, 0, 32'd0);
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule